// File: doc/BRIEF.md
# Handshaked Synchronous Serial Shift Port

The port moves data in both directions over one clock line, one data-out line and one data-in line. The peer controls the flow with a busy line. The port reports back with its own busy line and with a strobe that marks the end of a transfer. The port can make the transfer clock itself from the system clock (internal-clock mode). It can also take the clock from the peer on an input pin that it samples (external-clock mode). Data leaves least significant bit first: each bit changes on the falling clock edge, and the incoming bit is taken on the rising edge. Each received bit overwrites the transmitted bit in the same position of the same byte.

A handshake unit is one of three lengths:
- a full byte;
- a programmable number of bits, from 1 to 8;
- in auto mode, a run of bytes taken in order from a small on-chip buffer.

Once a unit has begun, the port always finishes it. One configuration bit selects how the strobe and the busy output behave in auto mode: once per byte, or once around the whole run. Three further bits set the polarity of the busy input, the busy output and the strobe. One more bit sets whether the data output floats while the peer asks for a stop.

A host loads bytes through the write port and pulses `start`. It then watches `xfer_busy` and reads the received bytes back through the read port.

Top module: `hsk_serial_port`

## Requirements
- R1: While `cfg_init` is 0, the port holds its idle state. In that state `xfer_busy` is 0, the strobe and the busy output sit at their inactive levels, `sclk_out` is 1, and a `start` pulse has no effect.
- R2: In internal-clock mode, `sclk_out` stays 1 until the synchronized busy input has been at its go level continuously for 3×(`cfg_div`+1) system clocks, which is 1.5 transfer-clock periods. A go period shorter than that produces no clock edge. The high and low phases of the transfer clock each last `cfg_div`+1 system clocks.
- R3: Once the first clock edge of a unit has been produced, the unit is completed in full, even if the busy input returns to its stop level.
- R4: Bits leave on `sout` least significant bit first, changing on the falling clock edge. `sin` is sampled on the rising edge. The bit received in position i replaces bit i of the byte in the buffer.
- R5: In byte mode (`cfg_mode`=00, or 11), a unit is 8 bits. In arbitrary mode (`cfg_mode`=01), a unit is `cfg_bitcnt`+1 bits. Buffer bits above the unit length keep their transmitted values.
- R6: In internal-clock mode only, the strobe is active for exactly 2×(`cfg_div`+1) system clocks, starting when the last rising edge of a unit has passed. In external-clock mode the strobe never becomes active.
- R7: `start` sets `xfer_busy`. In internal-clock mode, `xfer_busy` clears 2×(`cfg_div`+1) system clocks after the final strobe ends. In external-clock mode, it clears right after the last bit is sampled.
- R8: In auto mode (`cfg_mode`=10), `cfg_auto_len`+1 bytes are sent from buffer entries 0 upward. Each byte is replaced by the byte received in its place.
- R9: In auto mode with `cfg_auto_all`=0, a strobe follows every byte. With `cfg_auto_all`=1, a single strobe follows the last byte.
- R10: The busy output is active while a unit is being shifted. In auto mode with `cfg_auto_all`=1, it stays active for as long as `xfer_busy` is 1. In every case it is inactive whenever `xfer_busy` is 0.
- R11: In external-clock mode, edges on `sclk_in` are ignored while the busy input is at its stop level.
- R12: With `cfg_sout_hiz`=1, `sout_oe` is 1 only while the synchronized busy input is at its go level. With `cfg_sout_hiz`=0, `sout_oe` is always 1.
- R13: The busy input reads "stop" when it equals `cfg_bsyin_hi`. The busy output and the strobe drive `cfg_bsyout_hi` and `cfg_stb_hi` respectively when active, and the complement when inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_init | input | 1 | 0 holds the port in its idle state |
| cfg_ext_clk | input | 1 | 1 selects external-clock mode |
| cfg_mode | input | 2 | 00 byte, 01 arbitrary length, 10 auto, 11 byte |
| cfg_bitcnt | input | 3 | Unit length minus one in arbitrary mode |
| cfg_auto_len | input | IDX_W | Byte count minus one in auto mode |
| cfg_auto_all | input | 1 | Auto mode: strobe and busy span the whole run |
| cfg_div | input | DIV_W | Transfer-clock half period minus one, in system clocks |
| cfg_bsyin_hi | input | 1 | Busy input level that means stop |
| cfg_bsyout_hi | input | 1 | Active level of the busy output |
| cfg_stb_hi | input | 1 | Active level of the strobe |
| cfg_sout_hiz | input | 1 | Float the data output while the peer says stop |
| start | input | 1 | Begins a transfer |
| wr_en | input | 1 | Buffer write enable |
| wr_addr | input | IDX_W | Buffer write index |
| wr_data | input | 8 | Buffer write data |
| rd_addr | input | IDX_W | Buffer read index |
| rd_data | output | 8 | Buffer read data |
| busy_in | input | 1 | Hold-off request from the peer |
| sclk_in | input | 1 | Transfer clock from the peer |
| sin | input | 1 | Serial data in |
| sclk_out | output | 1 | Generated transfer clock, idles high |
| sout | output | 1 | Serial data out |
| sout_oe | output | 1 | Output enable for `sout` |
| busy_out | output | 1 | Stop request to the peer |
| stb_out | output | 1 | End-of-transfer strobe |
| xfer_busy | output | 1 | Transfer in progress |

## Verification
The bench plays the peer. It returns a chosen byte stream on `sin` and records every bit seen on `sout` at the rising clock edges. For each run it compares the bits seen and the buffer contents read back against a merge of the transmit and receive bytes computed in the bench.

Several directed patterns target specific faults:
- A busy input that starts at stop, then goes briefly to go, then goes to go properly and drops back to stop in the middle of the unit. This separates the 1.5-period admission rule from the rule that a started unit always finishes.
- Random bytes paired with random unit lengths. These expose errors in bit order and in length.
- Three-byte auto runs with each setting of the per-run bit. Counting the strobes and the busy-output pulses tells the two settings apart.
- An external-clock run in which the peer's first eight clock pulses fall under a stop level and carry different data. This shows whether gated edges leak through.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    localparam int BYTE_W   = 8;
    localparam int BIT_W    = $clog2(BYTE_W);
    localparam int GO_TICKS = 3;   // half periods of go before a unit may start

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SHIFT,
        ST_STB,
        ST_GAP
    } hsk_state_e;

    typedef enum logic [1:0] {
        MODE_BYTE = 2'b00,
        MODE_ARB  = 2'b01,
        MODE_AUTO = 2'b10
    } hsk_mode_e;

    function automatic logic [BIT_W:0] unit_len(input logic [1:0] mode,
                                                input logic [BIT_W-1:0] cnt);
        if (mode == MODE_ARB)
            return {1'b0, cnt} + 1'b1;
        return (BIT_W+1)'(BYTE_W);
    endfunction

    function automatic logic drive_lvl(input logic act, input logic hi);
        return act ? hi : ~hi;
    endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= rst_val;
            q    <= rst_val;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/hsk_tick_gen.sv
module hsk_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || !en || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hsk_byte_buf.sv
module hsk_byte_buf #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [W-1:0]     wr_data,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] wb_addr,
    input  logic [W-1:0]     wb_data,
    input  logic [IDX_W-1:0] ra_addr,
    output logic [W-1:0]     ra_data,
    input  logic [IDX_W-1:0] rb_addr,
    output logic [W-1:0]     rb_data
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst)
                mem[i] <= '0;
            else if (wb_en && wb_addr == IDX_W'(i))
                mem[i] <= wb_data;
            else if (wr_en && wr_addr == IDX_W'(i))
                mem[i] <= wr_data;
        end
    end

    assign ra_data = mem[ra_addr];
    assign rb_data = mem[rb_addr];
endmodule

// File: rtl/hsk_serial_port.sv
module hsk_serial_port
    import hsk_pkg::*;
#(
    parameter  int DIV_W     = 8,
    parameter  int BUF_DEPTH = 4,
    localparam int IDX_W     = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_init,
    input  logic               cfg_ext_clk,
    input  logic [1:0]         cfg_mode,
    input  logic [BIT_W-1:0]   cfg_bitcnt,
    input  logic [IDX_W-1:0]   cfg_auto_len,
    input  logic               cfg_auto_all,
    input  logic [DIV_W-1:0]   cfg_div,
    input  logic               cfg_bsyin_hi,
    input  logic               cfg_bsyout_hi,
    input  logic               cfg_stb_hi,
    input  logic               cfg_sout_hiz,
    input  logic               start,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic [IDX_W-1:0]   rd_addr,
    output logic [BYTE_W-1:0]  rd_data,
    input  logic               busy_in,
    input  logic               sclk_in,
    input  logic               sin,
    output logic               sclk_out,
    output logic               sout,
    output logic               sout_oe,
    output logic               busy_out,
    output logic               stb_out,
    output logic               xfer_busy
);
    // synchronized peer inputs
    logic busy_s, sclk_s, sin_s, sclk_d;
    logic go, tick, tick_en;

    hsk_sync #(.W(3)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d       ({busy_in, sclk_in, sin}),
        .rst_val ({cfg_bsyin_hi, 1'b1, 1'b0}),
        .q       ({busy_s, sclk_s, sin_s})
    );

    assign go = busy_s ^ cfg_bsyin_hi;

    // state
    hsk_state_e              state;
    logic                    flag, phase, sclk_r, sout_r;
    logic [1:0]              go_cnt;
    logic [BIT_W-1:0]        bit_idx;
    logic [IDX_W-1:0]        byte_idx;
    logic [BYTE_W-1:0]       sr, sr_upd, buf_q;
    logic [BIT_W:0]          len, len_m1;
    logic                    is_auto, unit_last, last_byte, strobe_now;
    logic                    do_rise, do_fall, wb_en;

    assign tick_en = !cfg_ext_clk &&
                     ((state == ST_WAIT) ? go
                                         : (state inside {ST_SHIFT, ST_STB, ST_GAP}));

    hsk_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk  (clk),
        .rst  (rst || !cfg_init),
        .en   (tick_en),
        .div  (cfg_div),
        .tick (tick)
    );

    assign is_auto    = (cfg_mode == MODE_AUTO);
    assign len        = unit_len(cfg_mode, cfg_bitcnt);
    assign len_m1     = len - 1'b1;
    assign unit_last  = (bit_idx == len_m1[BIT_W-1:0]);
    assign last_byte  = !is_auto || (byte_idx == cfg_auto_len);
    assign strobe_now = !cfg_ext_clk && (!is_auto || !cfg_auto_all || last_byte);

    assign do_rise = cfg_ext_clk ? (sclk_s && !sclk_d && go)  : (tick && phase);
    assign do_fall = cfg_ext_clk ? (!sclk_s && sclk_d && go)  : (tick && !phase);

    always_comb begin
        sr_upd = sr;
        if (state == ST_SHIFT && do_rise)
            sr_upd[bit_idx] = sin_s;
    end

    assign wb_en = (state == ST_SHIFT) && do_rise && unit_last;

    hsk_byte_buf #(.DEPTH(BUF_DEPTH), .W(BYTE_W), .IDX_W(IDX_W)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wb_en   (wb_en),
        .wb_addr (byte_idx),
        .wb_data (sr_upd),
        .ra_addr (rd_addr),
        .ra_data (rd_data),
        .rb_addr (byte_idx),
        .rb_data (buf_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sclk_d <= 1'b1;
        else
            sclk_d <= sclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst || !cfg_init) begin
            state    <= ST_IDLE;
            flag     <= 1'b0;
            phase    <= 1'b0;
            sclk_r   <= 1'b1;
            sout_r   <= 1'b1;
            go_cnt   <= '0;
            bit_idx  <= '0;
            byte_idx <= '0;
            sr       <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        flag     <= 1'b1;
                        byte_idx <= '0;
                        bit_idx  <= '0;
                        go_cnt   <= '0;
                        state    <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cfg_ext_clk) begin
                        sr    <= buf_q;
                        phase <= 1'b0;
                        state <= ST_SHIFT;
                    end else if (!go) begin
                        go_cnt <= '0;
                    end else if (tick) begin
                        if (go_cnt == 2'(GO_TICKS - 1)) begin
                            sr     <= buf_q;
                            phase  <= 1'b0;
                            go_cnt <= '0;
                            state  <= ST_SHIFT;
                        end else begin
                            go_cnt <= go_cnt + 1'b1;
                        end
                    end
                end
                ST_SHIFT: begin
                    if (do_fall) begin
                        if (!cfg_ext_clk)
                            sclk_r <= 1'b0;
                        sout_r <= sr[bit_idx];
                        phase  <= 1'b1;
                    end else if (do_rise) begin
                        sclk_r <= 1'b1;
                        phase  <= 1'b0;
                        sr     <= sr_upd;
                        if (unit_last) begin
                            bit_idx <= '0;
                            if (strobe_now) begin
                                state <= ST_STB;
                            end else if (last_byte) begin
                                state <= ST_IDLE;
                                flag  <= 1'b0;
                            end else begin
                                byte_idx <= byte_idx + 1'b1;
                                go_cnt   <= '0;
                                state    <= ST_WAIT;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_STB: begin
                    if (tick) begin
                        if (phase) begin
                            phase <= 1'b0;
                            state <= ST_GAP;
                        end else begin
                            phase <= 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (phase) begin
                            phase <= 1'b0;
                            if (last_byte) begin
                                state <= ST_IDLE;
                                flag  <= 1'b0;
                            end else begin
                                byte_idx <= byte_idx + 1'b1;
                                go_cnt   <= '0;
                                state    <= ST_WAIT;
                            end
                        end else begin
                            phase <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // outputs
    logic busy_act, stb_act;
    assign busy_act  = (state == ST_SHIFT) || (is_auto && cfg_auto_all && flag);
    assign stb_act   = (state == ST_STB);
    assign busy_out  = drive_lvl(busy_act, cfg_bsyout_hi);
    assign stb_out   = drive_lvl(stb_act, cfg_stb_hi);
    assign sclk_out  = cfg_ext_clk ? 1'b1 : sclk_r;
    assign sout      = sout_r;
    assign sout_oe   = !cfg_sout_hiz || go;
    assign xfer_busy = flag;

endmodule

// File: rtl/hsk_serial_chk.sv
module hsk_serial_chk (
    input logic clk,
    input logic rst,
    input logic cfg_init,
    input logic cfg_ext_clk,
    input logic cfg_sout_hiz,
    input logic cfg_stb_hi,
    input logic cfg_bsyout_hi,
    input logic go,
    input logic stb_out,
    input logic busy_out,
    input logic sout_oe,
    input logic xfer_busy
);
    logic stb_on;
    assign stb_on = (stb_out == cfg_stb_hi);

    AST_INIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_init |=> (!xfer_busy && stb_out == ~cfg_stb_hi && busy_out == ~cfg_bsyout_hi)); // R1

    AST_EXT_NO_STB: assert property (@(posedge clk) disable iff (rst)
        $rose(stb_on) |-> !$past(cfg_ext_clk)); // R6

    AST_STB_IN_FLAG: assert property (@(posedge clk) disable iff (rst)
        stb_on |-> xfer_busy); // R7

    AST_BUSY_IDLE: assert property (@(posedge clk) disable iff (rst)
        !xfer_busy |-> busy_out == ~cfg_bsyout_hi); // R10

    AST_HIZ_FLOAT: assert property (@(posedge clk) disable iff (rst)
        (cfg_sout_hiz && !go) |-> !sout_oe); // R12

endmodule

bind hsk_serial_port hsk_serial_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_init      (cfg_init),
    .cfg_ext_clk   (cfg_ext_clk),
    .cfg_sout_hiz  (cfg_sout_hiz),
    .cfg_stb_hi    (cfg_stb_hi),
    .cfg_bsyout_hi (cfg_bsyout_hi),
    .go            (go),
    .stb_out       (stb_out),
    .busy_out      (busy_out),
    .sout_oe       (sout_oe),
    .xfer_busy     (xfer_busy)
);

// File: tb/sim_hsk_serial_port.sv
`timescale 1ns/1ps
module sim_hsk_serial_port;
    localparam int DIV_W = 8;
    localparam int BUF_DEPTH = 4;
    localparam int IDX_W = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, cfg_init, cfg_ext_clk, cfg_auto_all;
    logic cfg_bsyin_hi, cfg_bsyout_hi, cfg_stb_hi, cfg_sout_hiz;
    logic [1:0] cfg_mode;
    logic [2:0] cfg_bitcnt;
    logic [IDX_W-1:0] cfg_auto_len, wr_addr, rd_addr;
    logic [DIV_W-1:0] cfg_div;
    logic start, wr_en, busy_in, sclk_in, ext_sin, int_sin, sin;
    logic [7:0] wr_data, rd_data;
    logic sclk_out, sout, sout_oe, busy_out, stb_out, xfer_busy;

    assign sin = cfg_ext_clk ? ext_sin : int_sin;

    hsk_serial_port #(.DIV_W(DIV_W), .BUF_DEPTH(BUF_DEPTH)) u0 (
        .clk(clk), .rst(rst), .cfg_init(cfg_init), .cfg_ext_clk(cfg_ext_clk),
        .cfg_mode(cfg_mode), .cfg_bitcnt(cfg_bitcnt), .cfg_auto_len(cfg_auto_len),
        .cfg_auto_all(cfg_auto_all), .cfg_div(cfg_div), .cfg_bsyin_hi(cfg_bsyin_hi),
        .cfg_bsyout_hi(cfg_bsyout_hi), .cfg_stb_hi(cfg_stb_hi), .cfg_sout_hiz(cfg_sout_hiz),
        .start(start), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy_in(busy_in), .sclk_in(sclk_in),
        .sin(sin), .sclk_out(sclk_out), .sout(sout), .sout_oe(sout_oe),
        .busy_out(busy_out), .stb_out(stb_out), .xfer_busy(xfer_busy)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // peer monitor
    logic [7:0]  rx_b [4];
    logic [31:0] cap;
    int unit_n = 8;
    int n_fall, n_rise, n_stb, n_bo, stb_w, last_stb_w, gap_w;
    bit in_gap, prev_sclk = 1'b1, prev_stb, prev_bo;

    always @(negedge clk) begin
        bit sa, ba;
        sa = (stb_out == cfg_stb_hi);
        ba = (busy_out == cfg_bsyout_hi);
        if (!cfg_ext_clk) begin
            if (prev_sclk && !sclk_out) begin
                if (n_fall / unit_n < 4) int_sin <= rx_b[n_fall / unit_n][n_fall % unit_n];
                n_fall++;
            end
            if (!prev_sclk && sclk_out) begin
                if (n_rise < 32) cap[n_rise] = sout;
                n_rise++;
            end
        end
        prev_sclk = sclk_out;
        if (sa) stb_w++;
        if (sa && !prev_stb) n_stb++;
        if (!sa && prev_stb) begin
            last_stb_w = stb_w; stb_w = 0; in_gap = 1'b1; gap_w = 0;
        end
        if (in_gap) begin
            if (xfer_busy && !sa) gap_w++;
            else in_gap = 1'b0;
        end
        if (ba && !prev_bo) n_bo++;
        prev_stb = sa;
        prev_bo = ba;
    end

    task automatic step(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic clr_mon();
        n_fall = 0; n_rise = 0; n_stb = 0; n_bo = 0; stb_w = 0;
        last_stb_w = 0; gap_w = 0; cap = '0;
    endtask

    task automatic set_go(input bit g);
        busy_in = g ? ~cfg_bsyin_hi : cfg_bsyin_hi;
    endtask

    task automatic wr(input int idx, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = IDX_W'(idx); wr_data = d; step(); wr_en = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [7:0] d);
        rd_addr = IDX_W'(idx); #1 d = rd_data;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (xfer_busy && t < 20000) begin step(); t++; end
    endtask

    task automatic pulse_start();
        start = 1'b1; step(); start = 1'b0;
    endtask

    function automatic logic [7:0] merge(input logic [7:0] tx, input logic [7:0] rx, input int n);
        logic [7:0] m;
        m = (n >= 8) ? 8'hFF : 8'((1 << n) - 1);
        return (tx & ~m) | (rx & m);
    endfunction

    function automatic logic [7:0] cap_unit(input int u, input int n);
        logic [7:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = cap[u*n + i];
        return r;
    endfunction

    function automatic logic [7:0] lowbits(input logic [7:0] v, input int n);
        return merge(8'h00, v, n);
    endfunction

    // one internal-clock run of nb units of n bits with busy held at go
    task automatic run_int(input int nb, input int n, input logic [7:0] tx [4], input string tag);
        logic [7:0] got;
        unit_n = n;
        for (int i = 0; i < nb; i++) wr(i, tx[i]);
        clr_mon();
        pulse_start();
        set_go(1'b1);
        wait_idle();
        set_go(1'b0);
        step(4);
        chk(n_rise == nb*n, tag, n_rise, nb*n);
        for (int i = 0; i < nb; i++) begin
            chk(cap_unit(i, n) == lowbits(tx[i], n), tag, cap_unit(i, n), lowbits(tx[i], n));
            rd(i, got);
            chk(got == merge(tx[i], rx_b[i], n), tag, got, merge(tx[i], rx_b[i], n));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] tx [4];
        logic [7:0] got;
        int t;
        void'($urandom(32'h5EED));
        rst = 1; cfg_init = 0; cfg_ext_clk = 0; cfg_mode = 2'b00; cfg_bitcnt = 3'd7;
        cfg_auto_len = '0; cfg_auto_all = 0; cfg_div = 8'd3; cfg_bsyin_hi = 1;
        cfg_bsyout_hi = 1; cfg_stb_hi = 1; cfg_sout_hiz = 0; start = 0; wr_en = 0;
        wr_addr = '0; wr_data = '0; rd_addr = '0; busy_in = 1; sclk_in = 1;
        ext_sin = 0; int_sin = 0;
        for (int i = 0; i < 4; i++) rx_b[i] = '0;
        step(3); rst = 0; step(2);

        // R1 idle state and ignored start
        chk(!xfer_busy && stb_out == 1'b0 && busy_out == 1'b0 && sclk_out, "R1 idle",
            {xfer_busy, stb_out, busy_out, sclk_out}, 4'b0001);
        pulse_start(); step(2);
        chk(!xfer_busy, "R1 start ignored", xfer_busy, 0);

        // R2 R3 R4 R6 R7 directed
        cfg_init = 1; step();
        wr(0, 8'hA5); rx_b[0] = 8'h3C; unit_n = 8; clr_mon();
        set_go(1'b0); pulse_start(); step(40);
        chk(n_fall == 0, "R2 no clock under stop", n_fall, 0);
        chk(xfer_busy, "R7 flag set by start", xfer_busy, 1);
        set_go(1'b1); step(8); set_go(1'b0); step(40);
        chk(n_fall == 0, "R2 short go", n_fall, 0);
        set_go(1'b1); t = 0;
        while (n_fall == 0 && t < 200) begin step(); t++; end
        chk(t >= 12 && t <= 22, "R2 admission delay", t, 18);
        while (n_rise < 3) step();
        set_go(1'b0);
        wait_idle(); step(4);
        chk(n_rise == 8, "R3 unit completes", n_rise, 8);
        chk(cap[7:0] == 8'hA5, "R4 lsb first out", cap[7:0], 8'hA5);
        rd(0, got);
        chk(got == 8'h3C, "R4 receive", got, 8'h3C);
        chk(n_stb == 1 && last_stb_w == 8, "R6 strobe width", last_stb_w, 8);
        chk(gap_w == 8, "R7 flag clear delay", gap_w, 8);

        // R4 R5 random bytes and lengths
        for (int k = 0; k < 6; k++) begin
            int n;
            cfg_mode = (k < 3) ? 2'b00 : 2'b01;
            cfg_bitcnt = 3'($urandom_range(0, 7));
            n = (cfg_mode == 2'b01) ? int'(cfg_bitcnt) + 1 : 8;
            tx[0] = 8'($urandom); rx_b[0] = 8'($urandom);
            run_int(1, n, tx, (k < 3) ? "R4 random byte" : "R5 arbitrary length");
        end
        cfg_mode = 2'b01; cfg_bitcnt = 3'd4;
        tx[0] = 8'hF0; rx_b[0] = 8'h0F;
        run_int(1, 5, tx, "R5 five bits");

        // R8 R9 R10 auto mode
        cfg_mode = 2'b10; cfg_auto_len = 2'd2;
        for (int i = 0; i < 3; i++) begin tx[i] = 8'($urandom); rx_b[i] = 8'($urandom); end
        cfg_auto_all = 0;
        run_int(3, 8, tx, "R8 auto per byte");
        chk(n_stb == 3, "R9 strobe per byte", n_stb, 3);
        chk(n_bo == 3, "R10 busy per byte", n_bo, 3);
        cfg_auto_all = 1;
        for (int i = 0; i < 3; i++) begin tx[i] = 8'($urandom); rx_b[i] = 8'($urandom); end
        run_int(3, 8, tx, "R8 auto whole run");
        chk(n_stb == 1, "R9 single strobe", n_stb, 1);
        chk(n_bo == 1, "R10 busy whole run", n_bo, 1);

        // R13 inverted polarities
        cfg_init = 0; cfg_mode = 2'b00; cfg_auto_all = 0;
        cfg_bsyin_hi = 0; cfg_bsyout_hi = 0; cfg_stb_hi = 0;
        set_go(1'b0); step(4);
        chk(busy_out == 1'b1 && stb_out == 1'b1, "R13 idle levels", {busy_out, stb_out}, 2'b11);
        cfg_init = 1; step();
        tx[0] = 8'h81; rx_b[0] = 8'h7E;
        run_int(1, 8, tx, "R13 inverted busy input");
        chk(n_stb == 1 && n_bo == 1, "R13 active levels", {n_stb[3:0], n_bo[3:0]}, 8'h11);
        cfg_init = 0; cfg_bsyin_hi = 1; cfg_bsyout_hi = 1; cfg_stb_hi = 1;
        set_go(1'b0); step(4);

        // R11 R6 external clock
        cfg_ext_clk = 1; cfg_init = 1; step();
        wr(0, 8'h5A); clr_mon(); cap = '0;
        pulse_start(); step(4);
        for (int i = 0; i < 8; i++) begin
            sclk_in = 0; ext_sin = 1'b1; step(6); sclk_in = 1; step(6);
        end
        chk(xfer_busy, "R11 edges ignored under stop", xfer_busy, 1);
        set_go(1'b1); step(4);
        for (int i = 0; i < 8; i++) begin
            sclk_in = 0; ext_sin = 8'hC3 >> i; step(5);
            cap[i] = sout; step(1); sclk_in = 1; step(6);
        end
        step(4); set_go(1'b0);
        rd(0, got);
        chk(!xfer_busy, "R7 ext flag clear", xfer_busy, 0);
        chk(got == 8'hC3, "R11 ext receive", got, 8'hC3);
        chk(cap[7:0] == 8'h5A, "R4 ext transmit", cap[7:0], 8'h5A);
        chk(n_stb == 0, "R6 no strobe in ext mode", n_stb, 0);
        cfg_init = 0; cfg_ext_clk = 0; step(2);

        // R12 output float
        cfg_init = 1; cfg_sout_hiz = 1; set_go(1'b0); step(4);
        chk(!sout_oe, "R12 float under stop", sout_oe, 0);
        set_go(1'b1); step(4);
        chk(sout_oe, "R12 drive under go", sout_oe, 1);
        cfg_sout_hiz = 0; set_go(1'b0); step(4);
        chk(sout_oe, "R12 always drive", sout_oe, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule